// File: doc/BRIEF.md
# Multi-width ALU with flags

This block is a purely combinational arithmetic and logic unit for a processor datapath that works on 8-, 16- and 32-bit values held in one 32-bit operand bus. A width select chooses how many low bits take part; every result and every flag is formed at that width, and the bits above it are driven to zero. The unit covers add and subtract (each with or without the incoming carry), compare, two's-complement negate, increment, decrement, the four bitwise operations and a flag probe that only inspects an operand.

Next to the result the unit returns the candidate values of five condition flags, a per-flag write-enable mask and a result write-enable. Each operation class owns its own subset of flags. A flag outside that subset is passed through unchanged on the flag output, so the surrounding pipeline can register the flag output directly or use the mask. The parity-style flag here is an "even" flag: it marks a result whose least significant bit is zero.

Top module: `alu_mw_top`

## Requirements
- R1: Width select 0 means 8 bits, 1 means 16 bits, 2 and the reserved code 3 mean 32 bits; operand bits above the selected width are ignored and result bits above it are zero.
- R2: Operation 0 (add) and 1 (add with carry-in taken from the carry flag) give A+B(+carry) at the selected width and enable all five flags; carry is the unsigned carry out of the top bit and overflow marks a sum that does not fit as a signed value.
- R3: Operation 2 (subtract) and 3 (subtract with borrow taken from the carry flag) give A-B(-carry); carry is set when B (plus the incoming carry for operation 3) exceeds A, overflow marks a signed result that does not fit, and all five flags are enabled.
- R4: Operation 4 (compare) produces exactly the flags and flag mask of subtract, places the difference on the result bus and holds the result write-enable low.
- R5: Operation 5 (negate) gives 0-A; carry is set when the result is non-zero, overflow is set only when A is the most negative value of the width, and all five flags are enabled.
- R6: Operations 6 (increment) and 7 (decrement) add or subtract one and enable only the zero and even flags.
- R7: Operations 8 (AND), 9 (OR), 10 (XOR) and 11 (NOT of A) enable all five flags, force carry and overflow to zero and form zero, even and negative from the result.
- R8: Operation 12 (probe) puts A masked to the width on the result bus, holds the result write-enable low and enables only zero, even and negative.
- R9: Flag vectors are ordered Z (bit 4), C (bit 3), O (bit 2), P (bit 1), N (bit 0); Z means the width-masked result is zero, P means its bit 0 is zero, N is its sign bit at the selected width.
- R10: Operation codes 13 to 15 drive a zero result with both write-enables inactive.
- R11: Every flag whose write-enable is low appears on the flag output with its incoming value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Width select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| flags_i | input | 5 | Current flags {Z,C,O,P,N} |
| result_o | output | 32 | Width-masked result |
| result_we_o | output | 1 | Result should be written back |
| flags_o | output | 5 | Next flags {Z,C,O,P,N} |
| flags_we_o | output | 5 | Per-flag write-enable, same order |

## Verification
The checker holds, at every evaluation, the structural rules: no result bit above the width, untouched flags equal to their inputs, zero and even flags agreeing with the result, the flag masks of increment, decrement and the bitwise group, the silent result of compare and probe, negate's carry rule and the idle behaviour of unused codes. Numeric correctness of sums, differences and the exact carry and overflow boundaries at each width (wrap at all-ones, signed limits, borrow with an incoming carry, negating the most negative value) can only be shown by the bench's directed scenarios against values computed from the requirements.

// File: rtl/alu_mw_pkg.sv
package alu_mw_pkg;

    localparam int DW = 32;
    localparam int FW = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBB  = 4'd3,
        OP_CMP   = 4'd4,
        OP_NEG   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_AND   = 4'd8,
        OP_OR    = 4'd9,
        OP_XOR   = 4'd10,
        OP_NOT   = 4'd11,
        OP_PROBE = 4'd12
    } op_e;

    // Bit order of every flag vector: z=4 c=3 o=2 p=1 n=0
    typedef struct packed {
        logic z;
        logic c;
        logic o;
        logic p;
        logic n;
    } flags_t;

    localparam logic [FW-1:0] FWE_ALL  = 5'b11111;
    localparam logic [FW-1:0] FWE_ZP   = 5'b10010;
    localparam logic [FW-1:0] FWE_ZPN  = 5'b10011;
    localparam logic [FW-1:0] FWE_NONE = 5'b00000;

    function automatic logic [DW-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: size_mask = DW'(8'hFF);
            SZ_HALF: size_mask = DW'(16'hFFFF);
            default: size_mask = {DW{1'b1}};
        endcase
    endfunction

    function automatic logic sign_of(logic [DW-1:0] v, size_e s);
        case (s)
            SZ_BYTE: sign_of = v[7];
            SZ_HALF: sign_of = v[15];
            default: sign_of = v[DW-1];
        endcase
    endfunction

    function automatic logic carry_at(logic [DW:0] v, size_e s);
        case (s)
            SZ_BYTE: carry_at = v[8];
            SZ_HALF: carry_at = v[16];
            default: carry_at = v[DW];
        endcase
    endfunction

    function automatic logic is_logic_op(op_e op);
        is_logic_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
    endfunction

endpackage

// File: rtl/alu_mw_arith.sv
module alu_mw_arith
    import alu_mw_pkg::*;
(
    input  op_e             op,
    input  size_e           sz,
    input  logic [DW-1:0]   a_m,
    input  logic [DW-1:0]   b_m,
    input  logic            cin,
    output logic [DW-1:0]   sum,
    output logic            carry,
    output logic            ovf
);
    logic [DW:0] ext;
    logic        sa, sb, sr;
    logic        is_sub;

    always_comb begin
        ext    = '0;
        is_sub = 1'b0;
        case (op)
            OP_ADD:  ext = {1'b0, a_m} + {1'b0, b_m};
            OP_ADDC: ext = {1'b0, a_m} + {1'b0, b_m} + {{DW{1'b0}}, cin};
            OP_SUB,
            OP_CMP: begin
                ext    = {1'b0, a_m} - {1'b0, b_m};
                is_sub = 1'b1;
            end
            OP_SUBB: begin
                ext    = {1'b0, a_m} - {1'b0, b_m} - {{DW{1'b0}}, cin};
                is_sub = 1'b1;
            end
            OP_NEG:  ext = {(DW+1){1'b0}} - {1'b0, a_m};
            OP_INC:  ext = {1'b0, a_m} + {{DW{1'b0}}, 1'b1};
            OP_DEC:  ext = {1'b0, a_m} - {{DW{1'b0}}, 1'b1};
            default: ext = '0;
        endcase
    end

    assign sum = ext[DW-1:0];
    assign sa  = sign_of(a_m, sz);
    assign sb  = sign_of(b_m, sz);
    assign sr  = sign_of(sum, sz);

    always_comb begin
        carry = 1'b0;
        ovf   = 1'b0;
        if (op == OP_NEG) begin
            carry = |(sum & size_mask(sz));
            ovf   = sa & sr;
        end else if (is_sub) begin
            // operands are masked, so a borrow always reaches the top bit
            carry = ext[DW];
            ovf   = (sa != sb) && (sr != sa);
        end else begin
            carry = carry_at(ext, sz);
            ovf   = (sa == sb) && (sr != sa);
        end
    end

endmodule

// File: rtl/alu_mw_logic.sv
module alu_mw_logic
    import alu_mw_pkg::*;
(
    input  op_e             op,
    input  logic [DW-1:0]   a_m,
    input  logic [DW-1:0]   b_m,
    output logic [DW-1:0]   res
);
    always_comb begin
        case (op)
            OP_AND:  res = a_m & b_m;
            OP_OR:   res = a_m | b_m;
            OP_XOR:  res = a_m ^ b_m;
            OP_NOT:  res = ~a_m;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_mw_flags.sv
module alu_mw_flags
    import alu_mw_pkg::*;
(
    input  logic [DW-1:0]   res_m,
    input  size_e           sz,
    input  logic            carry,
    input  logic            ovf,
    input  logic [FW-1:0]   we,
    input  logic [FW-1:0]   flags_in,
    output logic [FW-1:0]   flags_out
);
    flags_t calc;

    always_comb begin
        calc.z = (res_m == '0);
        calc.c = carry;
        calc.o = ovf;
        calc.p = ~res_m[0];
        calc.n = sign_of(res_m, sz);
    end

    for (genvar i = 0; i < FW; i++) begin : g_merge
        assign flags_out[i] = we[i] ? calc[i] : flags_in[i];
    end

endmodule

// File: rtl/alu_mw_top.sv
module alu_mw_top
    import alu_mw_pkg::*;
(
    input  logic [3:0]      op_i,
    input  logic [1:0]      size_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [FW-1:0]   flags_i,
    output logic [DW-1:0]   result_o,
    output logic            result_we_o,
    output logic [FW-1:0]   flags_o,
    output logic [FW-1:0]   flags_we_o
);
    op_e            op;
    size_e          sz;
    logic [DW-1:0]  mask, a_m, b_m;
    logic [DW-1:0]  arith_res, logic_res, raw;
    logic           arith_c, arith_o, fl_c, fl_o;
    flags_t         fin;

    assign op   = op_e'(op_i);
    assign sz   = size_e'(size_i);
    assign mask = size_mask(sz);
    assign a_m  = a_i & mask;
    assign b_m  = b_i & mask;
    assign fin  = flags_t'(flags_i);

    alu_mw_arith u_arith (
        .op    (op),
        .sz    (sz),
        .a_m   (a_m),
        .b_m   (b_m),
        .cin   (fin.c),
        .sum   (arith_res),
        .carry (arith_c),
        .ovf   (arith_o)
    );

    alu_mw_logic u_logic (
        .op  (op),
        .a_m (a_m),
        .b_m (b_m),
        .res (logic_res)
    );

    always_comb begin
        raw         = '0;
        result_we_o = 1'b0;
        flags_we_o  = FWE_NONE;
        fl_c        = 1'b0;
        fl_o        = 1'b0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_CMP, OP_NEG: begin
                raw         = arith_res;
                result_we_o = (op != OP_CMP);
                flags_we_o  = FWE_ALL;
                fl_c        = arith_c;
                fl_o        = arith_o;
            end
            OP_INC, OP_DEC: begin
                raw         = arith_res;
                result_we_o = 1'b1;
                flags_we_o  = FWE_ZP;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                raw         = logic_res;
                result_we_o = 1'b1;
                flags_we_o  = FWE_ALL;
            end
            OP_PROBE: begin
                raw         = a_m;
                flags_we_o  = FWE_ZPN;
            end
            default: ;
        endcase
    end

    assign result_o = raw & mask;

    alu_mw_flags u_flags (
        .res_m     (result_o),
        .sz        (sz),
        .carry     (fl_c),
        .ovf       (fl_o),
        .we        (flags_we_o),
        .flags_in  (flags_i),
        .flags_out (flags_o)
    );

endmodule

// File: rtl/alu_mw_chk.sv
module alu_mw_chk
    import alu_mw_pkg::*;
(
    input logic [3:0]      op_i,
    input logic [1:0]      size_i,
    input logic [DW-1:0]   a_i,
    input logic [DW-1:0]   b_i,
    input logic [FW-1:0]   flags_i,
    input logic [DW-1:0]   result_o,
    input logic            result_we_o,
    input logic [FW-1:0]   flags_o,
    input logic [FW-1:0]   flags_we_o
);
    logic [DW-1:0] wm;
    assign wm = size_mask(size_e'(size_i));

    always_comb begin
        // R1
        hi_bits_zero_chk: assert ((result_o & ~wm) == '0)
            else $error("result bits above width");
        // R11
        keep_flags_chk: assert (((flags_o ^ flags_i) & ~flags_we_o) == '0)
            else $error("disabled flag changed");
        // R9
        zero_flag_chk: assert (!flags_we_o[4] || (flags_o[4] == (result_o == '0)))
            else $error("zero flag disagrees with result");
        // R9
        even_flag_chk: assert (!flags_we_o[1] || (flags_o[1] == !result_o[0]))
            else $error("even flag disagrees with result");
        // R6
        incdec_mask_chk: assert (!(op_i == 4'd6 || op_i == 4'd7) || (flags_we_o == 5'b10010 && result_we_o))
            else $error("increment/decrement flag mask");
        // R7
        logic_clear_chk: assert (!(op_i >= 4'd8 && op_i <= 4'd11) || (flags_o[3:2] == 2'b00 && flags_we_o == 5'b11111))
            else $error("bitwise op did not clear carry/overflow");
        // R4
        cmp_no_write_chk: assert (op_i != 4'd4 || (!result_we_o && flags_we_o == 5'b11111))
            else $error("compare wrote a result");
        // R5
        neg_carry_chk: assert (op_i != 4'd5 || (flags_o[3] == (result_o != '0)))
            else $error("negate carry rule");
        // R8
        probe_mask_chk: assert (op_i != 4'd12 || (!result_we_o && flags_we_o == 5'b10011))
            else $error("probe mask");
        // R10
        undef_idle_chk: assert (op_i < 4'd13 || (result_o == '0 && !result_we_o && flags_we_o == '0))
            else $error("unused code not idle");
    end
endmodule

bind alu_mw_top alu_mw_chk u_chk (
    .op_i        (op_i),
    .size_i      (size_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .flags_i     (flags_i),
    .result_o    (result_o),
    .result_we_o (result_we_o),
    .flags_o     (flags_o),
    .flags_we_o  (flags_we_o)
);

// File: tb/tb_alu_mw_top.sv
module tb_alu_mw_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  flags_i = '0;
    logic [31:0] result_o;
    logic        result_we_o;
    logic [4:0]  flags_o;
    logic [4:0]  flags_we_o;

    int checks = 0;
    int errors = 0;
    bit reported = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    alu_mw_top dut (
        .op_i(op_i), .size_i(size_i), .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
        .result_o(result_o), .result_we_o(result_we_o),
        .flags_o(flags_o), .flags_we_o(flags_we_o)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Reference computed from the requirements with wide signed integers
    function automatic void model(input logic [3:0] op, input logic [1:0] sz,
                                  input logic [31:0] a, input logic [31:0] b, input logic [4:0] fin,
                                  output logic [31:0] r, output logic rwe,
                                  output logic [4:0] we, output logic [4:0] fo);
        longint w, m, ua, ub, sa, sb, sv, t, lo, hi, ci;
        logic c, o;
        logic [4:0] calc;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (longint'(1) << w) - 1;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        ua = longint'(a) & m;
        ub = longint'(b) & m;
        sa = (ua > hi) ? ua - (m + 1) : ua;
        sb = (ub > hi) ? ub - (m + 1) : ub;
        c = 0; o = 0; rwe = 1; we = 5'b11111; t = 0; ci = 0;
        case (op)
            4'd0, 4'd1: begin
                ci = (op == 4'd1) ? longint'(fin[3]) : 0;
                t = ua + ub + ci; c = (t > m);
                sv = sa + sb + ci; o = (sv > hi) || (sv < lo);
            end
            4'd2, 4'd3, 4'd4: begin
                ci = (op == 4'd3) ? longint'(fin[3]) : 0;
                t = ua - ub - ci; c = ((ub + ci) > ua);
                sv = sa - sb - ci; o = (sv > hi) || (sv < lo);
                rwe = (op != 4'd4);
            end
            4'd5: begin
                t = -ua; c = ((t & m) != 0); o = (ua == hi + 1);
            end
            4'd6: begin t = ua + 1; we = 5'b10010; end
            4'd7: begin t = ua - 1; we = 5'b10010; end
            4'd8:  t = ua & ub;
            4'd9:  t = ua | ub;
            4'd10: t = ua ^ ub;
            4'd11: t = ~ua;
            4'd12: begin t = ua; we = 5'b10011; rwe = 0; end
            default: begin t = 0; we = 5'b00000; rwe = 0; end
        endcase
        t = t & m;
        r = 32'(t);
        calc = {(t == 0), c, o, ~r[0], (t > hi)};
        fo = (calc & we) | (fin & ~we);
    endfunction

    task automatic apply(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] fin, input string tag);
        logic [31:0] er; logic erwe; logic [4:0] ewe, ef;
        @(negedge clk);
        op_i = op; size_i = sz; a_i = a; b_i = b; flags_i = fin;
        #1;
        model(op, sz, a, b, fin, er, erwe, ewe, ef);
        checks++;
        if (result_o !== er || result_we_o !== erwe || flags_we_o !== ewe || flags_o !== ef) begin
            errors++;
            $display("FAIL %s op=%0d sz=%0d a=%h b=%h: got res=%h rwe=%b we=%b fl=%b, expected res=%h rwe=%b we=%b fl=%b",
                     tag, op, sz, a, b, result_o, result_we_o, flags_we_o, flags_o, er, erwe, ewe, ef);
        end
    endtask

    // literal expectation on the inputs currently applied
    task automatic lit(input string tag, input logic [31:0] er, input logic erwe, input logic [4:0] ef);
        checks++;
        if (result_o !== er || result_we_o !== erwe || flags_o !== ef) begin
            errors++;
            $display("FAIL %s: got res=%h rwe=%b fl=%b, expected res=%h rwe=%b fl=%b",
                     tag, result_o, result_we_o, flags_o, er, erwe, ef);
        end
    endtask

    task automatic t_idle();
        apply(4'd0, 2'd0, 32'h0, 32'h0, 5'b00000, "R9 idle add of zeros");
        lit("R9 idle add of zeros", 32'h0, 1'b1, 5'b10010);
    endtask

    task automatic t_add();
        apply(4'd0, 2'd0, 32'hFF, 32'h01, 5'b00000, "R2 byte wrap");
        lit("R2 byte wrap", 32'h0, 1'b1, 5'b11010);
        apply(4'd0, 2'd1, 32'h7FFF, 32'h1, 5'b00000, "R2 half signed overflow");
        lit("R2 half signed overflow", 32'h8000, 1'b1, 5'b00111);
        apply(4'd1, 2'd2, 32'hFFFF_FFFF, 32'h0, 5'b01000, "R2 word carry-in");
        lit("R2 word carry-in", 32'h0, 1'b1, 5'b11010);
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 20; k++)
                apply(4'(k % 2), 2'(s), next_rand(), next_rand(), 5'(next_rand()), "R2 add patterns");
    endtask

    task automatic t_sub();
        apply(4'd2, 2'd0, 32'h3, 32'h5, 5'b00000, "R3 byte borrow");
        lit("R3 byte borrow", 32'hFE, 1'b1, 5'b01011);
        apply(4'd3, 2'd1, 32'h5, 32'h5, 5'b01000, "R3 borrow-in equal operands");
        lit("R3 borrow-in equal operands", 32'hFFFF, 1'b1, 5'b01001);
        apply(4'd2, 2'd2, 32'h8000_0000, 32'h1, 5'b00000, "R3 word signed overflow");
        lit("R3 word signed overflow", 32'h7FFF_FFFF, 1'b1, 5'b00100);
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 20; k++)
                apply(4'd2 + 4'(k % 2), 2'(s), next_rand(), next_rand(), 5'(next_rand()), "R3 sub patterns");
    endtask

    task automatic t_cmp();
        apply(4'd4, 2'd1, 32'h1234, 32'h1234, 5'b00000, "R4 compare equal");
        lit("R4 compare equal", 32'h0, 1'b0, 5'b10010);
        for (int k = 0; k < 30; k++)
            apply(4'd4, 2'(k % 3), next_rand(), next_rand(), 5'(next_rand()), "R4 compare patterns");
    endtask

    task automatic t_neg();
        apply(4'd5, 2'd0, 32'h80, 32'h0, 5'b00000, "R5 negate most negative");
        lit("R5 negate most negative", 32'h80, 1'b1, 5'b01111);
        apply(4'd5, 2'd2, 32'h0, 32'h0, 5'b01100, "R5 negate zero");
        lit("R5 negate zero", 32'h0, 1'b1, 5'b10010);
        for (int k = 0; k < 15; k++)
            apply(4'd5, 2'(k % 3), next_rand(), 32'h0, 5'(next_rand()), "R5 negate patterns");
    endtask

    task automatic t_incdec();
        apply(4'd6, 2'd0, 32'hFF, 32'h0, 5'b01101, "R6 increment wrap keeps C O N");
        lit("R6 increment wrap keeps C O N", 32'h0, 1'b1, 5'b11111);
        apply(4'd7, 2'd1, 32'h0, 32'h0, 5'b10010, "R6 decrement wrap");
        lit("R6 decrement wrap", 32'hFFFF, 1'b1, 5'b00000);
        for (int k = 0; k < 20; k++)
            apply(4'd6 + 4'(k % 2), 2'(k % 3), next_rand(), 32'h0, 5'(next_rand()), "R6 inc/dec patterns");
    endtask

    task automatic t_logic();
        apply(4'd11, 2'd1, 32'hFFFF_00FF, 32'h0, 5'b01100, "R7 NOT half clears C O");
        lit("R7 NOT half clears C O", 32'hFF00, 1'b1, 5'b00011);
        apply(4'd8, 2'd0, 32'hF0, 32'h0F, 5'b01100, "R7 AND to zero");
        lit("R7 AND to zero", 32'h0, 1'b1, 5'b10010);
        for (int k = 0; k < 40; k++)
            apply(4'd8 + 4'(k % 4), 2'(k % 3), next_rand(), next_rand(), 5'(next_rand()), "R7 bitwise patterns");
    endtask

    task automatic t_probe();
        apply(4'd12, 2'd1, 32'h0001_2345, 32'hDEAD, 5'b01110, "R8 probe half");
        lit("R8 probe half", 32'h2345, 1'b0, 5'b01100);
        apply(4'd12, 2'd0, 32'h0000_1280, 32'h0, 5'b01000, "R8 probe byte negative");
        lit("R8 probe byte negative", 32'h80, 1'b0, 5'b01011);
    endtask

    task automatic t_width();
        apply(4'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 5'b00000, "R1 reserved width is 32");
        lit("R1 reserved width is 32", 32'h0, 1'b1, 5'b11010);
        apply(4'd9, 2'd0, 32'hABCD_EF00, 32'h1234_5601, 5'b00000, "R1 upper bits ignored");
        lit("R1 upper bits ignored", 32'h01, 1'b1, 5'b00000);
    endtask

    task automatic t_undef();
        for (int c = 13; c < 16; c++) begin
            apply(4'(c), 2'd2, 32'hFFFF_FFFF, 32'h5, 5'b10101, "R10 unused code");
            lit("R11 unused code keeps flags", 32'h0, 1'b0, 5'b10101);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_neg();
        t_incdec();
        t_logic();
        t_probe();
        t_width();
        t_undef();
        repeat (2) @(posedge clk);
        report();
    end

endmodule